// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing heart of a pulse-width generator. A 16-bit counter steps on an enable tick from a two-stage clock prescaler. Depending on the selected count mode it climbs from zero to the period and wraps, descends from the period to zero and wraps, bounces between the two in a triangle, or holds still. A downstream action block uses the outputs to decide when the waveform edges fall: the live count, a direction flag, and single-cycle strobes when the counter lands on zero and on the period.

Software sets the block up through a small register port that has one write strobe and a combinational read. Address 0 holds the control word. Address 1 takes the period, either straight into the active register or into a shadow copy that moves over when the counter next reaches zero. Address 2 presets the counter. Address 3 reads back the shadow period. A run-behaviour field chooses among three settings: stop after one more step, stop at the end of the current cycle, or run freely.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the period registers are 0, the direction flag is 1, both strobes are low, and the control word reads 16'h0003 (hold mode, stop-after-one-step run setting, shadowed period, division 1).
- R2: Control bits [1:0]=00 select up mode. On each step the counter increments, and from a value at or above the period it goes to 0. The direction flag reads 1.
- R3: Control bits [1:0]=01 select down mode. On each step the counter decrements, and from 0 it goes to the active period. The direction flag reads 0.
- R4: Control bits [1:0]=10 select up-down mode. The counter rises to the period, then falls to 0, and turns around at each end. The direction flag shows the current direction.
- R5: Control bits [1:0]=11 hold the counter at its value, and no strobes are produced.
- R6: The step rate is the clock divided by 2^C times H. C is control bits [12:10]. H is 1 when control bits [9:7] are 0, and twice their value otherwise. Any register write restarts the prescaler, so the first step lands exactly that many cycles after the write.
- R7: Control bit 3 = 1 makes a period write take effect at once. When it is 0, the write goes to the shadow register, which is copied to the active period on the step that brings the counter to 0.
- R8: On a step whose new count is 0, zeroEvt is high for the next clock cycle. On a step whose new count equals the active period, prdEvt is high for that cycle. Both strobes are low at all other times.
- R9: Control bits [15:14]=00 (stop-after-one-step) let the counter make exactly one more step after the control write, and then it halts.
- R10: Control bits [15:14]=01 (stop at the end of the cycle) halt the counter at the period in up mode, at 0 in down mode, and at 0 on the falling half in up-down mode.
- R11: A write to address 2 loads the counter. Reads return the control word at address 0, the active period at 1, the count at 2 and the shadow period at 3. Writes to address 3 are ignored.
- R12: Control bit 15 set (codes 10 and 11) lets the counter run without halting. A control write clears any halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register address for writes and reads |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for addr |
| cnt | output | 16 | Current counter value |
| dirUp | output | 1 | 1 while counting up |
| zeroEvt | output | 1 | Strobe: counter stepped to zero |
| prdEvt | output | 1 | Strobe: counter stepped to the period |

## Verification
The bench builds the block with its default 16-bit counter and 3-bit prescaler fields. This puts the largest division, 1792, within reach of one directed measurement, alongside the smallest division and a mid-range one. The random phase keeps periods at or below 15 and division factors small, so a run of twenty thousand cycles covers many wraps, turnarounds, shadow transfers and halts in every mode and run setting.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  localparam int ADDR_W = 2;
  localparam int CTRL_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SHD  = 2'd3;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    RS_STEP  = 2'b00,
    RS_CYCLE = 2'b01,
    RS_FREEA = 2'b10,
    RS_FREE  = 2'b11
  } run_sel_e;

  // Strobes handed from the control side to the counter datapath
  typedef struct packed {
    logic      adv;
    logic      preset;
    cnt_mode_e mode;
  } tb_strobe_t;

endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale #(
  parameter int CW = 3,
  parameter int HW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic [CW-1:0] coarse,
  input  logic [HW-1:0] hs,
  output logic          tick
);
  localparam int MAX_HS  = 2 * ((1 << HW) - 1);
  localparam int MAX_DIV = (1 << ((1 << CW) - 1)) * MAX_HS;
  localparam int PW      = $clog2(MAX_DIV + 1);

  logic [PW-1:0] preCnt;
  logic [PW-1:0] hsFactor;
  logic [PW-1:0] divLast;

  always_comb begin
    hsFactor = (hs == '0) ? PW'(1) : PW'({hs, 1'b0});
    divLast  = (hsFactor << coarse) - PW'(1);
  end

  assign tick = (preCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (restart || tick) preCnt <= '0;
    else                      preCnt <= preCnt + PW'(1);
  end
endmodule

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dirUp,
  input  logic              enterZero,
  output tb_strobe_t        strobe,
  output logic [CNT_W-1:0]  prdAct,
  output logic [CNT_W-1:0]  prdShd,
  output logic [CTRL_W-1:0] ctrlWord,
  output cnt_mode_e         modeSel,
  output run_sel_e          runSel
);
  logic       immLoad;
  logic [2:0] hsDiv;
  logic [2:0] coarseDiv;
  logic       halted;
  logic       tick;
  logic       endCond;
  logic       stepOk;
  logic       ctrlWr;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  pwm_tb_prescale #(.CW(3), .HW(3)) u_pre (
    .clk    (clk),
    .rstN   (rstN),
    .restart(wrEn),
    .coarse (coarseDiv),
    .hs     (hsDiv),
    .tick   (tick)
  );

  // End of the current cycle, per count mode
  always_comb begin
    unique case (modeSel)
      CM_UP:   endCond = (cnt >= prdAct);
      CM_DOWN: endCond = (cnt == '0);
      CM_UPDN: endCond = (cnt == '0) && !dirUp;
      default: endCond = 1'b0;
    endcase
  end

  assign stepOk = tick && (modeSel != CM_HOLD) && !halted && !wrEn;

  always_comb begin
    strobe.mode   = modeSel;
    strobe.preset = wrEn && (addr == ADDR_CNT);
    strobe.adv    = stepOk && !((runSel == RS_CYCLE) && endCond);
  end

  always_comb begin
    ctrlWord        = '0;
    ctrlWord[1:0]   = modeSel;
    ctrlWord[3]     = immLoad;
    ctrlWord[9:7]   = hsDiv;
    ctrlWord[12:10] = coarseDiv;
    ctrlWord[15:14] = runSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel   <= CM_HOLD;
      runSel    <= RS_STEP;
      immLoad   <= 1'b0;
      hsDiv     <= '0;
      coarseDiv <= '0;
      halted    <= 1'b0;
    end else if (ctrlWr) begin
      modeSel   <= cnt_mode_e'(wrData[1:0]);
      immLoad   <= wrData[3];
      hsDiv     <= wrData[9:7];
      coarseDiv <= wrData[12:10];
      runSel    <= run_sel_e'(wrData[15:14]);
      halted    <= 1'b0;
    end else if (stepOk && ((runSel == RS_STEP) ||
                            ((runSel == RS_CYCLE) && endCond))) begin
      halted <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prdAct <= '0;
      prdShd <= '0;
    end else if (wrEn && (addr == ADDR_PRD)) begin
      prdShd <= wrData;
      if (immLoad) prdAct <= wrData;
    end else if (enterZero) begin
      prdAct <= prdShd;
    end
  end
endmodule

// File: rtl/pwm_tb_datapath.sv
module pwm_tb_datapath
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tb_strobe_t       strobe,
  input  logic [CNT_W-1:0] presetVal,
  input  logic [CNT_W-1:0] prdAct,
  output logic [CNT_W-1:0] cnt,
  output logic             dirUp,
  output logic             zeroEvt,
  output logic             prdEvt,
  output logic             enterZero
);
  logic [CNT_W-1:0] nxt;
  logic             udDir;
  logic             nxtUd;

  always_comb begin
    nxt   = cnt;
    nxtUd = udDir;
    unique case (strobe.mode)
      CM_UP:   nxt = (cnt >= prdAct) ? '0 : cnt + CNT_W'(1);
      CM_DOWN: nxt = (cnt == '0) ? prdAct : cnt - CNT_W'(1);
      CM_UPDN: begin
        if (udDir) begin
          if (cnt >= prdAct) begin
            nxtUd = 1'b0;
            nxt   = (cnt == '0) ? '0 : cnt - CNT_W'(1);
          end else begin
            nxt = cnt + CNT_W'(1);
          end
        end else begin
          if (cnt == '0) begin
            nxtUd = 1'b1;
            nxt   = (prdAct == '0) ? '0 : CNT_W'(1);
          end else begin
            nxt = cnt - CNT_W'(1);
          end
        end
      end
      default: nxt = cnt;
    endcase
  end

  assign enterZero = strobe.adv && (nxt == '0);

  always_comb begin
    unique case (strobe.mode)
      CM_UP:   dirUp = 1'b1;
      CM_DOWN: dirUp = 1'b0;
      default: dirUp = udDir;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      udDir   <= 1'b1;
      zeroEvt <= 1'b0;
      prdEvt  <= 1'b0;
    end else begin
      zeroEvt <= strobe.adv && (nxt == '0);
      prdEvt  <= strobe.adv && (nxt == prdAct);
      if (strobe.preset) begin
        cnt <= presetVal;
      end else if (strobe.adv) begin
        cnt   <= nxt;
        udDir <= nxtUd;
      end
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [CNT_W-1:0]  cnt,
  output logic              dirUp,
  output logic              zeroEvt,
  output logic              prdEvt
);
  tb_strobe_t        strobe;
  logic [CNT_W-1:0]  prdAct;
  logic [CNT_W-1:0]  prdShd;
  logic [CTRL_W-1:0] ctrlWord;
  cnt_mode_e         modeSel;
  run_sel_e          runSel;
  logic              enterZero;

  pwm_tb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .cnt      (cnt),
    .dirUp    (dirUp),
    .enterZero(enterZero),
    .strobe   (strobe),
    .prdAct   (prdAct),
    .prdShd   (prdShd),
    .ctrlWord (ctrlWord),
    .modeSel  (modeSel),
    .runSel   (runSel)
  );

  pwm_tb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .presetVal(wrData),
    .prdAct   (prdAct),
    .cnt      (cnt),
    .dirUp    (dirUp),
    .zeroEvt  (zeroEvt),
    .prdEvt   (prdEvt),
    .enterZero(enterZero)
  );

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = CNT_W'(ctrlWord);
      ADDR_PRD:  rdData = prdAct;
      ADDR_CNT:  rdData = cnt;
      default:   rdData = prdShd;
    endcase
  end
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CNT_W-1:0] cnt,
  input logic             zeroEvt,
  input logic             prdEvt,
  input logic [1:0]       modeSel,
  input logic [1:0]       runSel,
  input logic [CNT_W-1:0] prdAct
);
  // R5: hold mode keeps the count
  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11 && !wrEn) |=> $stable(cnt));

  // R8: zero strobe only with a zero count
  p_zero_evt_r8: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |-> (cnt == '0));

  // R8: period strobe only with the count on the active period
  p_prd_evt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (prdEvt && !zeroEvt) |-> (cnt == prdAct));

  // R2: up mode below the period moves by at most +1
  p_up_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && !wrEn && cnt < prdAct) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

  // R3: down mode above zero moves by at most -1
  p_down_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 && !wrEn && cnt != '0) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

  // R10: end-of-cycle run setting parks an up count on the period
  p_cycle_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (runSel == 2'b01 && modeSel == 2'b00 && cnt == prdAct && !wrEn) |=> $stable(cnt));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .cnt    (cnt),
  .zeroEvt(zeroEvt),
  .prdEvt (prdEvt),
  .modeSel(modeSel),
  .runSel (runSel),
  .prdAct (prdAct)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  addr;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic [15:0] cnt;
  logic        dirUp;
  logic        zeroEvt;
  logic        prdEvt;

  int checks = 0;
  int failures = 0;

  pwm_timebase u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cnt(cnt), .dirUp(dirUp), .zeroEvt(zeroEvt), .prdEvt(prdEvt)
  );

  always #10 clk = ~clk;

  // Reference state
  logic [1:0]  mMode, mRun;
  logic        mImm, mUd, mHalt, mZ, mP;
  logic [2:0]  mCo, mHs;
  logic [15:0] mAct, mShd, mCnt;
  int          mPre;

  function automatic int fDiv(input logic [2:0] co, input logic [2:0] hs);
    return (1 << co) * ((hs == 0) ? 1 : 2 * int'(hs));
  endfunction

  function automatic logic fDir();
    return (mMode == 2'b00) ? 1'b1 : (mMode == 2'b01) ? 1'b0 : mUd;
  endfunction

  function automatic logic [15:0] fRead(input logic [1:0] a);
    case (a)
      2'd0: return {mRun, 1'b0, mCo, mHs, 3'b000, mImm, 1'b0, mMode};
      2'd1: return mAct;
      2'd2: return mCnt;
      default: return mShd;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mReset();
    mMode = 2'b11; mRun = 2'b00; mImm = 1'b0; mCo = 3'd0; mHs = 3'd0;
    mAct = 16'd0; mShd = 16'd0; mCnt = 16'd0; mUd = 1'b1; mHalt = 1'b0;
    mZ = 1'b0; mP = 1'b0; mPre = 0;
  endtask

  task automatic mStep(input logic w, input logic [1:0] a, input logic [15:0] d);
    int dv;
    logic tk, stepOk, endC, adv, nud, nZ, nP;
    logic [15:0] nxt;
    dv = fDiv(mCo, mHs);
    tk = (mPre == dv - 1);
    stepOk = tk && (mMode != 2'b11) && !mHalt && !w;
    nxt = mCnt; nud = mUd; endC = 1'b0;
    case (mMode)
      2'b00: begin nxt = (mCnt >= mAct) ? 16'd0 : mCnt + 16'd1; endC = (mCnt >= mAct); end
      2'b01: begin nxt = (mCnt == 0) ? mAct : mCnt - 16'd1; endC = (mCnt == 0); end
      2'b10: begin
        endC = (mCnt == 0) && !mUd;
        if (mUd) begin
          if (mCnt >= mAct) begin nud = 1'b0; nxt = (mCnt == 0) ? 16'd0 : mCnt - 16'd1; end
          else nxt = mCnt + 16'd1;
        end else begin
          if (mCnt == 0) begin nud = 1'b1; nxt = (mAct == 0) ? 16'd0 : 16'd1; end
          else nxt = mCnt - 16'd1;
        end
      end
      default: ;
    endcase
    adv = stepOk && !((mRun == 2'b01) && endC);
    nZ = adv && (nxt == 0);
    nP = adv && (nxt == mAct);
    if (stepOk && ((mRun == 2'b00) || ((mRun == 2'b01) && endC))) mHalt = 1'b1;
    if (adv) begin
      mCnt = nxt; mUd = nud;
      if (nxt == 0) mAct = mShd;
    end
    if (w) mPre = 0; else if (tk) mPre = 0; else mPre = mPre + 1;
    if (w) begin
      case (a)
        2'd0: begin
          mMode = d[1:0]; mImm = d[3]; mHs = d[9:7]; mCo = d[12:10]; mRun = d[15:14];
          mHalt = 1'b0;
        end
        2'd1: begin mShd = d; if (mImm) mAct = d; end
        2'd2: mCnt = d;
        default: ;
      endcase
    end
    mZ = nZ; mP = nP;
  endtask

  // One clock: drive at negedge, check read, advance, compare after edge
  task automatic cyc(input logic w, input logic [1:0] a, input logic [15:0] d);
    string tag;
    wrEn = w; addr = a; wrData = d;
    #1;
    chk(rdData == fRead(a), "R11 read port", rdData, fRead(a));
    mStep(w, a, d);
    @(posedge clk);
    @(negedge clk);
    case (mMode)
      2'b00: tag = "R2 up count";
      2'b01: tag = "R3 down count";
      2'b10: tag = "R4 up-down count";
      default: tag = "R5 hold count";
    endcase
    chk(cnt == mCnt, tag, cnt, mCnt);
    chk(dirUp == fDir(), "R4 direction flag", dirUp, fDir());
    chk(zeroEvt == mZ, "R8 zero strobe", zeroEvt, mZ);
    chk(prdEvt == mP, "R8 period strobe", prdEvt, mP);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd2, 16'd0);
  endtask

  task automatic measureDiv(input logic [2:0] co, input logic [2:0] hs);
    int n;
    logic [15:0] start;
    cyc(1'b1, 2'd0, 16'h000B);
    cyc(1'b1, 2'd1, 16'd100);
    cyc(1'b1, 2'd2, 16'd0);
    cyc(1'b1, 2'd0, {2'b11, 1'b0, co, hs, 3'b000, 1'b1, 1'b0, 2'b00});
    start = cnt;
    n = 0;
    do begin
      cyc(1'b0, 2'd2, 16'd0);
      n++;
    end while (cnt == start && n < 4000);
    chk(n == fDiv(co, hs), "R6 prescaler division", n, fDiv(co, hs));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2718));
    wrEn = 1'b0; addr = 2'd0; wrData = 16'd0; rstN = 1'b0;
    mReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    addr = 2'd0; #1;
    chk(rdData == 16'h0003, "R1 control after reset", rdData, 16'h0003);
    chk(cnt == 16'd0, "R1 count after reset", cnt, 0);
    chk(dirUp == 1'b1, "R1 direction after reset", dirUp, 1);
    chk(!zeroEvt && !prdEvt, "R1 strobes after reset", {zeroEvt, prdEvt}, 0);
    idle(10);
    chk(cnt == 16'd0, "R5 hold keeps count", cnt, 0);

    // R7 shadow load at zero
    cyc(1'b1, 2'd1, 16'd5);
    addr = 2'd1; #1;
    chk(rdData == 16'd0, "R7 shadow write leaves active", rdData, 0);
    cyc(1'b1, 2'd0, 16'hC000);
    idle(2);
    addr = 2'd1; #1;
    chk(rdData == 16'd5, "R7 shadow moved at zero", rdData, 5);
    idle(20);

    // R7 immediate load
    cyc(1'b1, 2'd0, 16'h000B);
    cyc(1'b1, 2'd1, 16'd9);
    addr = 2'd1; #1;
    chk(rdData == 16'd9, "R7 immediate period", rdData, 9);

    // R6 division law
    measureDiv(3'd0, 3'd0);
    measureDiv(3'd0, 3'd7);
    measureDiv(3'd2, 3'd3);
    measureDiv(3'd7, 3'd7);

    // R9 stop after one step
    cyc(1'b1, 2'd0, 16'h000B);
    cyc(1'b1, 2'd1, 16'd10);
    cyc(1'b1, 2'd2, 16'd5);
    cyc(1'b1, 2'd0, 16'h0008);
    idle(20);
    chk(cnt == 16'd6, "R9 single step then halt", cnt, 6);

    // R10 end of cycle, up and down
    cyc(1'b1, 2'd1, 16'd7);
    cyc(1'b1, 2'd2, 16'd0);
    cyc(1'b1, 2'd0, 16'h4008);
    idle(40);
    chk(cnt == 16'd7, "R10 up halts on period", cnt, 7);
    cyc(1'b1, 2'd2, 16'd5);
    cyc(1'b1, 2'd0, 16'h4009);
    idle(40);
    chk(cnt == 16'd0, "R10 down halts on zero", cnt, 0);
    cyc(1'b1, 2'd0, 16'hC00A);
    idle(3);
    cyc(1'b1, 2'd0, 16'h400A);
    idle(40);
    chk(cnt == 16'd0 && dirUp == 1'b0, "R10 up-down halts on falling zero", cnt, 0);

    // R12 run code 10 keeps running
    cyc(1'b1, 2'd2, 16'd0);
    cyc(1'b1, 2'd0, 16'h8008);
    idle(43);
    chk(cnt == 16'd3, "R12 free run wraps", cnt, 3);

    // R4 triangle and R11 preset / ignored address
    cyc(1'b1, 2'd1, 16'd3);
    cyc(1'b1, 2'd2, 16'd0);
    cyc(1'b1, 2'd0, 16'hC00A);
    idle(30);
    cyc(1'b1, 2'd0, 16'h000B);
    cyc(1'b1, 2'd2, 16'h1234);
    addr = 2'd2; #1;
    chk(rdData == 16'h1234, "R11 preset readback", rdData, 16'h1234);
    cyc(1'b1, 2'd3, 16'hBEEF);
    addr = 2'd3; #1;
    chk(rdData == 16'd3, "R11 write to address 3 ignored", rdData, 3);

    // Constrained random phase
    for (int i = 0; i < 20000; i++) begin
      int r;
      logic [1:0] rMode, rRun, rA;
      logic [2:0] rCo, rHs;
      logic rImm;
      r = $urandom_range(0, 29);
      rA = 2'($urandom_range(0, 3));
      if (r == 0) begin
        rMode = 2'($urandom_range(0, 3));
        rRun  = 2'($urandom_range(0, 3));
        rImm  = 1'($urandom_range(0, 1));
        rCo   = 3'($urandom_range(0, 2));
        rHs   = 3'($urandom_range(0, 3));
        cyc(1'b1, 2'd0, {rRun, 1'b0, rCo, rHs, 3'b000, rImm, 1'b0, rMode});
      end else if (r == 1) begin
        cyc(1'b1, 2'd1, 16'($urandom_range(0, 15)));
      end else if (r == 2) begin
        cyc(1'b1, 2'd2, 16'($urandom_range(0, 20)));
      end else if (r == 3) begin
        cyc(1'b1, 2'd3, 16'($urandom_range(0, 65535)));
      end else begin
        cyc(1'b0, rA, 16'd0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule